// File: doc/BRIEF.md
# Error-Correcting Synchronous SRAM Controller

This block sits between a simple host request port and a 45-bit-wide asynchronous SRAM. Every 32-bit word is stored as a 45-bit codeword. The codeword is a shortened binary BCH code over GF(64), built on the primitive polynomial x^6+x+1 with generator x^12+x^10+x^8+x^5+x^4+x^3+1, plus one overall parity bit. It corrects any two flipped bits in a word and detects three. The host asks for 8-, 16- or 32-bit reads and writes. Reads go through a single-cycle decode step. When that step repairs a word, the repaired word is re-encoded and written back to the same location, so that soft errors do not pile up.

A 32-bit write encodes the word and stores it straight away. An 8- or 16-bit write first reads the whole word and corrects it. It then merges the new lanes, re-encodes the word and stores it. A word that cannot be corrected is never written: reads return its raw data with an error flag, and sub-word writes to it are dropped. A saturating counter of corrected accesses and a sticky uncorrectable flag are visible at the ports.

Top module: `sramEdacTop`

## Requirements
- R1: A 32-bit write (reqWrite=1, reqSize=2 or 3) performs no SRAM read. It holds its single SRAM write for WAIT_STATES+1 cycles and raises rspValid WAIT_STATES+2 cycles after acceptance.
- R2: For reads, reqSize 0 returns the byte selected by reqAddr[1:0] and reqSize 1 returns the half selected by reqAddr[1]. Both are right-justified and zero-extended. reqSize 2 or 3 returns the whole word, in which byte n sits at bits 8n+7..8n.
- R3: Any one or two flipped bits in a stored codeword, the parity bit included, are corrected. rspCorrected is set and the returned data matches what was last written.
- R4: A corrected read writes the re-encoded word back, so the stored codeword equals the one held before the upset. rspValid follows acceptance by 2*WAIT_STATES+4 cycles; a clean read takes WAIT_STATES+3.
- R5: Three flipped bits give rspUncorr=1, rspCorrected=0 and the raw stored data. No SRAM write follows, and rspValid comes WAIT_STATES+3 cycles after acceptance.
- R6: An 8- or 16-bit write reads, corrects, merges the new bytes (taken from the low bits of reqWdata, placed by the lane rule of R2) and writes the word. rspValid comes 2*WAIT_STATES+4 cycles after acceptance.
- R7: An 8- or 16-bit write to an uncorrectable word reports rspUncorr=1 and leaves the stored codeword untouched.
- R8: reqReady is high only when idle. It falls after acceptance and stays low through the one-cycle rspValid pulse.
- R9: corrCount rises by one for each access whose decode corrected something and saturates at its maximum. uncorrSticky sets on any uncorrectable decode and clears only on reset.
- R10: Chip select is low during every SRAM cycle. Output enable and write enable are never low together. Each SRAM read and write cycle lasts WAIT_STATES+1 clocks.
- R11: After reset reqReady=1, rspValid=0, corrCount=0, uncorrSticky=0, and all SRAM strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 half, 2/3 word |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write data, right-justified for sub-word |
| reqReady | output | 1 | Idle, request accepted this cycle if valid |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data, valid with rspValid on reads |
| rspCorrected | output | 1 | Access needed correction |
| rspUncorr | output | 1 | Access hit an uncorrectable word |
| corrCount | output | CNT_W | Saturating corrected-access count |
| uncorrSticky | output | 1 | Sticky uncorrectable flag |
| sramAddr | output | ADDR_W-2 | SRAM word address |
| sramWdata | output | 45 | Codeword to SRAM |
| sramRdata | input | 45 | Codeword from SRAM |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |

## Verification
The bench builds the block with WAIT_STATES=1, ADDR_W=8 and CNT_W=3. The short wait count keeps every latency in a handful of cycles, so the exact cycle counts of each path can be checked. The 3-bit counter lets a few corrected reads reach saturation and prove that it holds there. The 64-word SRAM model lets each upset pattern sit in its own word.

// File: rtl/sramEdacPkg.sv
package sramEdacPkg;
  localparam int DATA_W = 32;
  localparam int CHK_W = 12;
  localparam int CW_W = 45;
  localparam int POS_N = 44;
  localparam logic [CHK_W-1:0] GEN_LOW = 12'h539;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_DECODE, ST_WRITEBACK, ST_WRITE, ST_DONE
  } stateT;

  typedef struct packed {
    logic latchReq;
    logic captureRaw;
    logic latchDecode;
  } strobeT;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic corr;
    logic uncorr;
  } decodeT;

  function automatic logic [5:0] alphaPow(input int e);
    logic [5:0] a;
    int r;
    a = 6'd1;
    r = e % 63;
    for (int k = 0; k < 63; k++)
      if (k < r) a = {a[4:0], 1'b0} ^ (a[5] ? 6'h03 : 6'h00);
    return a;
  endfunction

  function automatic logic [5:0] gfMul(input logic [5:0] a, input logic [5:0] b);
    logic [5:0] r;
    r = '0;
    for (int i = 5; i >= 0; i--) begin
      r = {r[4:0], 1'b0} ^ (r[5] ? 6'h03 : 6'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [CW_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] rem;
    logic fb;
    logic [CW_W-1:0] cw;
    rem = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = d[i] ^ rem[CHK_W-1];
      rem = {rem[CHK_W-2:0], 1'b0};
      if (fb) rem = rem ^ GEN_LOW;
    end
    cw[CHK_W-1:0] = rem;
    cw[POS_N-1:CHK_W] = d;
    cw[CW_W-1] = ^{d, rem};
    return cw;
  endfunction

  function automatic decodeT decodeWord(input logic [CW_W-1:0] cw);
    logic [5:0] s1, s3, s1sq, s1cu, cnst, a, t;
    logic [POS_N-1:0] flip;
    logic par, single, ok;
    int roots;
    decodeT res;
    s1 = '0;
    s3 = '0;
    for (int j = 0; j < POS_N; j++)
      if (cw[j]) begin
        s1 = s1 ^ alphaPow(j);
        s3 = s3 ^ alphaPow(3 * j);
      end
    par = ^cw;
    s1sq = gfMul(s1, s1);
    s1cu = gfMul(s1sq, s1);
    cnst = s1cu ^ s3;
    flip = '0;
    roots = 0;
    if (s1 != 6'd0)
      for (int j = 0; j < POS_N; j++) begin
        a = alphaPow(j);
        t = gfMul(s1, gfMul(a, a)) ^ gfMul(s1sq, a) ^ cnst;
        if (t == 6'd0) begin
          flip[j] = 1'b1;
          roots++;
        end
      end
    single = (s3 == s1cu);
    if (s1 == 6'd0) ok = (s3 == 6'd0);
    else if (par) ok = (roots == 1) && single;
    else ok = (roots == 2) || ((roots == 1) && single);
    res.data = ok ? (cw[POS_N-1:CHK_W] ^ flip[POS_N-1:CHK_W]) : cw[POS_N-1:CHK_W];
    res.corr = ok && ((s1 != 6'd0) || par);
    res.uncorr = !ok;
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] mergeLanes(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] wd, input logic [1:0] size, input logic [1:0] off);
    logic [DATA_W-1:0] w;
    w = old;
    if (size == 2'd0) w[8*off +: 8] = wd[7:0];
    else if (size == 2'd1) w[16*off[1] +: 16] = wd[15:0];
    else w = wd;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] selectLanes(input logic [DATA_W-1:0] w,
      input logic [1:0] size, input logic [1:0] off);
    logic [DATA_W-1:0] r;
    r = '0;
    if (size == 2'd0) r[7:0] = w[8*off +: 8];
    else if (size == 2'd1) r[15:0] = w[16*off[1] +: 16];
    else r = w;
    return r;
  endfunction
endpackage

// File: rtl/sramEdacCtrl.sv
module sramEdacCtrl
  import sramEdacPkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   reqFull,
  input  logic   isWrite,
  input  logic   decCorr,
  input  logic   decUncorr,
  output strobeT strobe,
  output logic   reqReady,
  output logic   rspValid,
  output logic   sramCeN,
  output logic   sramOeN,
  output logic   sramWeN
);
  localparam int CW = $clog2(WAIT_STATES + 2);
  localparam logic [CW-1:0] LAST = CW'(WAIT_STATES);

  stateT state, nextState;
  logic [CW-1:0] waitCnt;
  logic accept, cycleEnd, memCycle;

  assign accept = (state == ST_IDLE) && reqValid;
  assign cycleEnd = (waitCnt == LAST);
  assign memCycle = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WRITEBACK);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (accept) nextState = (reqWrite && reqFull) ? ST_WRITE : ST_READ;
      ST_READ: if (cycleEnd) nextState = ST_DECODE;
      ST_DECODE:
        if (decUncorr) nextState = ST_DONE;
        else if (isWrite) nextState = ST_WRITE;
        else if (decCorr) nextState = ST_WRITEBACK;
        else nextState = ST_DONE;
      ST_WRITEBACK, ST_WRITE: if (cycleEnd) nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      waitCnt <= (memCycle && !cycleEnd) ? waitCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    strobe.latchReq = accept;
    strobe.captureRaw = (state == ST_READ) && cycleEnd;
    strobe.latchDecode = (state == ST_DECODE);
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign sramCeN = !memCycle;
  assign sramOeN = (state != ST_READ);
  assign sramWeN = !((state == ST_WRITE) || (state == ST_WRITEBACK));
endmodule

// File: rtl/sramEdacDatapath.sv
module sramEdacDatapath
  import sramEdacPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              isWrite,
  output logic              decCorr,
  output logic              decUncorr,
  output logic [31:0]       rspRdata,
  output logic              rspCorrected,
  output logic              rspUncorr,
  output logic [CNT_W-1:0]  corrCount,
  output logic              uncorrSticky,
  output logic [ADDR_W-3:0] sramAddr,
  output logic [CW_W-1:0]   sramWdata,
  input  logic [CW_W-1:0]   sramRdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] addrR;
  logic [1:0] sizeR;
  logic writeR, corrR, uncorrR, stickyR;
  logic [31:0] wdataR, wordR;
  logic [CW_W-1:0] rawR;
  logic [CNT_W-1:0] cntR;
  decodeT dec;

  assign dec = decodeWord(rawR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR <= '0;
      sizeR <= '0;
      writeR <= 1'b0;
      wdataR <= '0;
      wordR <= '0;
      rawR <= '0;
      corrR <= 1'b0;
      uncorrR <= 1'b0;
      cntR <= '0;
      stickyR <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        addrR <= reqAddr;
        sizeR <= reqSize;
        writeR <= reqWrite;
        wdataR <= reqWdata;
        wordR <= reqWdata;
        corrR <= 1'b0;
        uncorrR <= 1'b0;
      end
      if (strobe.captureRaw) rawR <= sramRdata;
      if (strobe.latchDecode) begin
        wordR <= writeR ? mergeLanes(dec.data, wdataR, sizeR, addrR[1:0]) : dec.data;
        corrR <= dec.corr;
        uncorrR <= dec.uncorr;
        if (dec.corr && cntR != CNT_MAX) cntR <= cntR + 1'b1;
        if (dec.uncorr) stickyR <= 1'b1;
      end
    end
  end

  assign isWrite = writeR;
  assign decCorr = dec.corr;
  assign decUncorr = dec.uncorr;
  assign rspRdata = selectLanes(wordR, sizeR, addrR[1:0]);
  assign rspCorrected = corrR;
  assign rspUncorr = uncorrR;
  assign corrCount = cntR;
  assign uncorrSticky = stickyR;
  assign sramAddr = addrR[ADDR_W-1:2];
  assign sramWdata = encodeWord(wordR);
endmodule

// File: rtl/sramEdacTop.sv
module sramEdacTop
  import sramEdacPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WAIT_STATES = 2,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspCorrected,
  output logic              rspUncorr,
  output logic [CNT_W-1:0]  corrCount,
  output logic              uncorrSticky,
  output logic [ADDR_W-3:0] sramAddr,
  output logic [44:0]       sramWdata,
  input  logic [44:0]       sramRdata,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN
);
  strobeT strobe;
  logic isWrite, decCorr, decUncorr;

  sramEdacCtrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqFull(reqSize[1]), .isWrite(isWrite), .decCorr(decCorr),
    .decUncorr(decUncorr), .strobe(strobe), .reqReady(reqReady),
    .rspValid(rspValid), .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  sramEdacDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .isWrite(isWrite), .decCorr(decCorr), .decUncorr(decUncorr),
    .rspRdata(rspRdata), .rspCorrected(rspCorrected), .rspUncorr(rspUncorr),
    .corrCount(corrCount), .uncorrSticky(uncorrSticky), .sramAddr(sramAddr),
    .sramWdata(sramWdata), .sramRdata(sramRdata)
  );
endmodule

// File: rtl/sramEdacChecker.sv
module sramEdacChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspCorrected,
  input logic             rspUncorr,
  input logic [CNT_W-1:0] corrCount,
  input logic             uncorrSticky,
  input logic             sramCeN,
  input logic             sramOeN,
  input logic             sramWeN
);
  p_oe_we_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));
  p_we_ce_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN || !sramOeN) |-> !sramCeN);
  p_busy_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspCorrected && rspUncorr));
  p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rstN)
    corrCount != '0 |=> corrCount >= $past(corrCount));
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    uncorrSticky |=> uncorrSticky);
endmodule

bind sramEdacTop sramEdacChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspCorrected(rspCorrected), .rspUncorr(rspUncorr),
  .corrCount(corrCount), .uncorrSticky(uncorrSticky), .sramCeN(sramCeN),
  .sramOeN(sramOeN), .sramWeN(sramWeN)
);

// File: tb/test_sramEdacTop.sv
module test_sramEdacTop;
  localparam int AW = 8;
  localparam int WS = 1;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspValid, rspCorrected, rspUncorr, uncorrSticky;
  logic [31:0] rspRdata;
  logic [CW-1:0] corrCount;
  logic [AW-3:0] sramAddr;
  logic [44:0] sramWdata, sramRdata;
  logic sramCeN, sramOeN, sramWeN;

  logic [44:0] mem [0:63];
  logic flipReq = 1'b0;
  logic [5:0] flipIdx = '0;
  logic [44:0] flipMask = '0;
  int rdTotal = 0, wrTotal = 0;

  int errors = 0, checks = 0;
  int lat, rdUsed, wrUsed, expCnt;
  logic [31:0] gotData, refMem [0:63];
  logic gotCorr, gotUncorr;
  logic [44:0] gold [0:63];
  logic [44:0] saved;
  logic busyBad;

  always #10 clk = ~clk;

  sramEdacTop #(.ADDR_W(AW), .WAIT_STATES(WS), .CNT_W(CW)) i_sramEdacTop (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspCorrected(rspCorrected), .rspUncorr(rspUncorr), .corrCount(corrCount),
    .uncorrSticky(uncorrSticky), .sramAddr(sramAddr), .sramWdata(sramWdata),
    .sramRdata(sramRdata), .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  assign sramRdata = (!sramCeN && !sramOeN) ? mem[sramAddr] : 45'h0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else if (flipReq) begin
      mem[flipIdx] <= mem[flipIdx] ^ flipMask;
    end else if (!sramCeN && !sramWeN) begin
      mem[sramAddr] <= sramWdata;
    end
    if (!sramOeN) rdTotal <= rdTotal + 1;
    if (!sramWeN) wrTotal <= wrTotal + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic inject(input int idx, input logic [44:0] mask);
    @(negedge clk);
    flipIdx = 6'(idx);
    flipMask = mask;
    flipReq = 1'b1;
    @(negedge clk);
    flipReq = 1'b0;
  endtask

  task automatic runReq(input logic wr, input logic [1:0] sz, input logic [AW-1:0] ad,
                        input logic [31:0] wd);
    int rd0, wr0;
    @(negedge clk);
    chk("R8 ready high when idle", reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = ad; reqWdata = wd;
    rd0 = rdTotal; wr0 = wrTotal;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    busyBad = 1'b0;
    while (!rspValid && lat < 40) begin
      if (reqReady) busyBad = 1'b1;
      @(negedge clk);
      lat++;
    end
    if (reqReady) busyBad = 1'b1;
    gotData = rspRdata; gotCorr = rspCorrected; gotUncorr = rspUncorr;
    @(negedge clk);
    rdUsed = rdTotal - rd0; wrUsed = wrTotal - wr0;
    chk("R8 ready low while busy", busyBad, 0);
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] w, input logic [1:0] sz,
                                        input logic [1:0] off);
    if (sz == 2'd0) return (w >> (8 * off)) & 32'hFF;
    if (sz == 2'd1) return (w >> (16 * off[1])) & 32'hFFFF;
    return w;
  endfunction

  task automatic bump();
    if (expCnt < 7) expCnt++;
  endtask

  initial begin
    expCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 ready", reqReady, 1);
    chk("R11 rspValid", rspValid, 0);
    chk("R11 count", corrCount, 0);
    chk("R11 sticky", uncorrSticky, 0);
    chk("R11 strobes", {sramCeN, sramOeN, sramWeN}, 3'b111);

    for (int i = 0; i < 8; i++) begin
      refMem[i] = 32'h1357_9BDF * (i + 3) ^ 32'hA5C3_0F1E;
      runReq(1'b1, 2'd2, AW'(i * 4), refMem[i]);
      chk("R1 write latency", lat, WS + 2);
      chk("R1 no read", rdUsed, 0);
      chk("R10 write length", wrUsed, WS + 1);
      gold[i] = mem[i];
    end

    runReq(1'b0, 2'd2, AW'(4), 32'h0);
    chk("R2 word read", gotData, refMem[1]);
    chk("R4 clean latency", lat, WS + 3);
    chk("R3 clean flag", gotCorr, 0);
    chk("R10 read length", rdUsed, WS + 1);
    for (int o = 0; o < 4; o++) begin
      runReq(1'b0, 2'd0, AW'(8 + o), 32'h0);
      chk("R2 byte read", gotData, lanes(refMem[2], 2'd0, 2'(o)));
    end
    for (int o = 0; o < 2; o++) begin
      runReq(1'b0, 2'd1, AW'(12 + 2 * o), 32'h0);
      chk("R2 half read", gotData, lanes(refMem[3], 2'd1, 2'(2 * o)));
    end

    inject(2, 45'h1 << 20);
    runReq(1'b0, 2'd2, AW'(8), 32'h0);
    chk("R3 single data", gotData, refMem[2]);
    chk("R3 corr flag", gotCorr, 1);
    chk("R4 corrected latency", lat, 2 * WS + 4);
    chk("R4 writeback content", mem[2], gold[2]);
    chk("R10 writeback length", wrUsed, WS + 1);
    bump();
    chk("R9 count", corrCount, expCnt);

    inject(3, (45'h1 << 13) | (45'h1 << 40));
    runReq(1'b0, 2'd1, AW'(14), 32'h0);
    chk("R3 double data", gotData, lanes(refMem[3], 2'd1, 2'd2));
    chk("R4 double writeback", mem[3], gold[3]);
    bump();

    inject(4, (45'h1 << 3) | (45'h1 << 30));
    runReq(1'b0, 2'd0, AW'(17), 32'h0);
    chk("R3 check+data", gotData, lanes(refMem[4], 2'd0, 2'd1));
    chk("R4 check+data writeback", mem[4], gold[4]);
    bump();

    inject(5, 45'h1 << 44);
    runReq(1'b0, 2'd2, AW'(20), 32'h0);
    chk("R3 parity only", {gotCorr, gotData}, {1'b1, refMem[5]});
    chk("R4 parity writeback", mem[5], gold[5]);
    bump();

    inject(1, (45'h1 << 25) | (45'h1 << 44));
    runReq(1'b0, 2'd2, AW'(4), 32'h0);
    chk("R3 data+parity", {gotCorr, gotData}, {1'b1, refMem[1]});
    chk("R4 data+parity writeback", mem[1], gold[1]);
    bump();
    chk("R9 count after five", corrCount, expCnt);

    inject(0, (45'h1 << 13) | (45'h1 << 25) | (45'h1 << 40));
    saved = mem[0];
    runReq(1'b0, 2'd2, AW'(0), 32'h0);
    chk("R5 raw data", gotData, refMem[0] ^ 32'h1000_2002);
    chk("R5 flags", {gotUncorr, gotCorr}, 2'b10);
    chk("R5 latency", lat, WS + 3);
    chk("R5 no write", wrUsed, 0);
    chk("R5 memory kept", mem[0], saved);
    chk("R9 sticky", uncorrSticky, 1);
    chk("R9 count unchanged", corrCount, expCnt);

    runReq(1'b1, 2'd0, AW'(1), 32'h0000_00EE);
    chk("R7 flag", gotUncorr, 1);
    chk("R7 memory kept", mem[0], saved);
    refMem[0] = 32'h0BAD_F00D;
    runReq(1'b1, 2'd2, AW'(0), refMem[0]);
    chk("R9 sticky holds", uncorrSticky, 1);

    runReq(1'b1, 2'd0, AW'(6), 32'h1234_56A5);
    chk("R6 byte write latency", lat, 2 * WS + 4);
    refMem[1] = (refMem[1] & 32'hFF00_FFFF) | 32'h00A5_0000;
    runReq(1'b0, 2'd2, AW'(4), 32'h0);
    chk("R6 byte merge", gotData, refMem[1]);

    runReq(1'b1, 2'd1, AW'(10), 32'hFFFF_C0DE);
    refMem[2] = (refMem[2] & 32'h0000_FFFF) | 32'hC0DE_0000;
    runReq(1'b0, 2'd2, AW'(8), 32'h0);
    chk("R6 half merge", gotData, refMem[2]);

    inject(3, 45'h1 << 15);
    runReq(1'b1, 2'd1, AW'(12), 32'h0000_7E57);
    chk("R6 merge on corrected word flag", gotCorr, 1);
    bump();
    refMem[3] = (refMem[3] & 32'hFFFF_0000) | 32'h0000_7E57;
    runReq(1'b0, 2'd2, AW'(12), 32'h0);
    chk("R6 merge after correction", {gotCorr, gotData}, {1'b0, refMem[3]});

    for (int k = 0; k < 4; k++) begin
      inject(4, 45'h1 << (12 + k));
      runReq(1'b0, 2'd2, AW'(16), 32'h0);
      chk("R3 repeated correction", gotData, refMem[4]);
      bump();
    end
    chk("R9 saturated count", corrCount, expCnt);
    chk("R9 saturated at max", corrCount, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule